// File: doc/BRIEF.md
# GPIO Bank with Per-Line Interrupt Triggers

This block is one bank of general-purpose I/O lines behind a small memory-mapped register port. Software sets each line's direction and output value, reads back the line state, and arms an interrupt on each line. The interrupt can be set to fire on a rising edge, a falling edge, either edge, a high level or a low level.

Each line's pin input passes through a two-flop synchronizer. A third flop keeps the previous synchronized value, which the edge detector compares against. Each line's trigger kind comes from three bits, one bit in each of three type registers. Captured events land in a single status register. Software clears status bits by writing ones to them. A single summary interrupt stays high while any enabled line has its status bit set.

The register port is a plain address, write strobe and write data interface. Read data is registered. Two base-address parameters place the register group anywhere in a larger map: one for the value pair and one for the interrupt group.

Top module: `gpio_irq_bank`

## Requirements
- R1: While reset is held, and after it is released, every register is zero, `rd_data` is 0, `irq` is 0 and `pin_oe` is 0.
- R2: A write to VAL_BASE+0x04 sets the direction register. Bit value 1 makes the line an output: its `pin_oe` bit goes high and `pin_out` carries the output latch. A write to VAL_BASE+0x00 loads the output latch for all lines, including the input lines.
- R3: A read of VAL_BASE+0x00 returns the output latch bit for output lines and the synchronized pin bit for input lines. `rd_data` appears on the clock edge after the address is presented.
- R4: The interrupt group sits at IRQ_BASE and can be read back. Enable is at +0x00, trigger bit 0 at +0x04, trigger bit 1 at +0x08, trigger bit 2 at +0x0C and status at +0x10.
- R5: With trigger bits (bit2,bit1,bit0) = 001, a 0-to-1 change of the synchronized pin sets the status bit. With 000, a 1-to-0 change sets it. The status bit becomes visible three clock edges after the pin changes.
- R6: With bit1 = 0 and bit2 = 1, either edge sets the status bit, whatever the value of bit0 (codes 101 and 100).
- R7: With bit1 = 1, the line is level sensitive. Bit0 = 1 selects the high level and bit0 = 0 the low level. While the level is held, a status bit that was cleared sets again one cycle after the clear.
- R8: A write to the status address clears each status bit written with 1 and leaves bits written with 0 unchanged. When a clear and a new event hit the same bit in the same cycle, the clear wins.
- R9: A status bit only sets while its enable bit is 1. Clearing an enable bit does not clear a status bit that is already set.
- R10: `irq` is high exactly when some line has both its status bit and its enable bit set.
- R11: Every address other than the seven mapped ones reads as 0, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | Register byte address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | LINES | Write data |
| rd_data | output | LINES | Registered read data |
| pin_in | input | LINES | Asynchronous pin inputs |
| pin_out | output | LINES | Output latch value |
| pin_oe | output | LINES | Output enable, 1 = drive |
| irq | output | 1 | Summary interrupt |

## Verification
Two cases are hard to reach from the ports: a clear that lands while a level is still active, and a clear that meets a new event on the same bit in the same cycle. To reach them, the stimulus holds the pins of level-mode lines steady across a status write. It also times a pin toggle so that the synchronized edge arrives on the clock edge where the clear is written. A behavioural model tracks the pin history in a queue and is compared with every output on every clock. This catches a one-cycle slip in the synchronizer depth or in the set-versus-clear ordering.

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank #(
  parameter int LINES    = 32,
  parameter int ADDR_W   = 12,
  parameter int VAL_BASE = 'h000,
  parameter int IRQ_BASE = 'h008
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [LINES-1:0]  wr_data,
  output logic [LINES-1:0]  rd_data,
  input  logic [LINES-1:0]  pin_in,
  output logic [LINES-1:0]  pin_out,
  output logic [LINES-1:0]  pin_oe,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(VAL_BASE);
  localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(VAL_BASE + 'h04);
  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(IRQ_BASE);
  localparam logic [ADDR_W-1:0] A_TY0  = ADDR_W'(IRQ_BASE + 'h04);
  localparam logic [ADDR_W-1:0] A_TY1  = ADDR_W'(IRQ_BASE + 'h08);
  localparam logic [ADDR_W-1:0] A_TY2  = ADDR_W'(IRQ_BASE + 'h0C);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(IRQ_BASE + 'h10);

  logic [LINES-1:0] sync1, sync2, prev;
  logic [LINES-1:0] latch, dir, en_q, ty0, ty1, ty2, stat_q;
  logic [LINES-1:0] rise, fall, lvl_hit, edge_hit, hit, clr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
      prev  <= '0;
    end else begin
      sync1 <= pin_in;
      sync2 <= sync1;
      prev  <= sync2;
    end
  end

  assign rise     = sync2 & ~prev;
  assign fall     = ~sync2 & prev;
  assign lvl_hit  = ~(ty0 ^ sync2);
  assign edge_hit = (ty2 & (rise | fall)) | (~ty2 & ((ty0 & rise) | (~ty0 & fall)));
  assign hit      = ((ty1 & lvl_hit) | (~ty1 & edge_hit)) & en_q;
  assign clr      = (wr_en && addr == A_STAT) ? wr_data : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latch  <= '0;
      dir    <= '0;
      en_q   <= '0;
      ty0    <= '0;
      ty1    <= '0;
      ty2    <= '0;
      stat_q <= '0;
    end else begin
      if (wr_en) begin
        case (addr)
          A_DATA: latch <= wr_data;
          A_DIR:  dir   <= wr_data;
          A_EN:   en_q  <= wr_data;
          A_TY0:  ty0   <= wr_data;
          A_TY1:  ty1   <= wr_data;
          A_TY2:  ty2   <= wr_data;
          default: ;
        endcase
      end
      stat_q <= (stat_q | hit) & ~clr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rd_data <= '0;
    else begin
      case (addr)
        A_DATA:  rd_data <= (dir & latch) | (~dir & sync2);
        A_DIR:   rd_data <= dir;
        A_EN:    rd_data <= en_q;
        A_TY0:   rd_data <= ty0;
        A_TY1:   rd_data <= ty1;
        A_TY2:   rd_data <= ty2;
        A_STAT:  rd_data <= stat_q;
        default: rd_data <= '0;
      endcase
    end
  end

  assign pin_out = latch;
  assign pin_oe  = dir;
  assign irq     = |(stat_q & en_q);
endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk #(
  parameter int LINES    = 32,
  parameter int ADDR_W   = 12,
  parameter int VAL_BASE = 'h000,
  parameter int IRQ_BASE = 'h008
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic [LINES-1:0]  wr_data,
  input logic [LINES-1:0]  rd_data,
  input logic [LINES-1:0]  pin_oe,
  input logic              irq,
  input logic [LINES-1:0]  en_q,
  input logic [LINES-1:0]  stat_q
);
  localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(VAL_BASE + 'h04);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(IRQ_BASE + 'h10);

  logic mapped;
  assign mapped = addr == ADDR_W'(VAL_BASE) || addr == A_DIR ||
                  addr == ADDR_W'(IRQ_BASE) || addr == ADDR_W'(IRQ_BASE + 'h04) ||
                  addr == ADDR_W'(IRQ_BASE + 'h08) || addr == ADDR_W'(IRQ_BASE + 'h0C) ||
                  addr == A_STAT;

  // R8
  w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_STAT) |=> ((stat_q & $past(wr_data)) == '0));

  // R9
  no_set_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(en_q)) == '0));

  // R2
  dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == A_DIR) |=> $stable(pin_oe));

  // R11
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mapped |=> rd_data == '0);

  // R10
  irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (en_q != '0));
endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(
  .LINES(LINES), .ADDR_W(ADDR_W), .VAL_BASE(VAL_BASE), .IRQ_BASE(IRQ_BASE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
  .rd_data(rd_data), .pin_oe(pin_oe), .irq(irq), .en_q(en_q), .stat_q(stat_q)
);

// File: tb/test_gpio_irq_bank.sv
module test_gpio_irq_bank;
  localparam int N = 32;
  logic          clk = 0;
  logic          rst_n = 0;
  logic [11:0]   addr = '0;
  logic          wr_en = 0;
  logic [N-1:0]  wr_data = '0;
  logic [N-1:0]  pin_in = '0;
  logic [N-1:0]  rd_data, pin_out, pin_oe;
  logic          irq;

  gpio_irq_bank i_gpio_irq_bank (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  always #4 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;
  string cur_req = "R1";

  logic [N-1:0] m_latch, m_dir, m_en, m_t0, m_t1, m_t2, m_stat, m_rd;
  logic [N-1:0] seen[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_latch = '0; m_dir = '0; m_en = '0; m_t0 = '0; m_t1 = '0; m_t2 = '0;
      m_stat = '0; m_rd = '0;
      seen = {'0, '0, '0};
    end else begin
      logic [N-1:0] cur, old, hits, nrd;
      cur = seen[1];
      old = seen[2];
      hits = '0;
      for (int i = 0; i < N; i++) begin
        bit r, f;
        r = cur[i] && !old[i];
        f = !cur[i] && old[i];
        case ({m_t2[i], m_t1[i], m_t0[i]})
          3'b000:          hits[i] = f;
          3'b001:          hits[i] = r;
          3'b100, 3'b101:  hits[i] = r || f;
          3'b010, 3'b110:  hits[i] = !cur[i];
          default:         hits[i] = cur[i];
        endcase
      end
      hits &= m_en;
      case (addr)
        12'h000: nrd = (m_dir & m_latch) | (~m_dir & cur);
        12'h004: nrd = m_dir;
        12'h008: nrd = m_en;
        12'h00C: nrd = m_t0;
        12'h010: nrd = m_t1;
        12'h014: nrd = m_t2;
        12'h018: nrd = m_stat;
        default: nrd = '0;
      endcase
      m_rd = nrd;
      m_stat = m_stat | hits;
      if (wr_en) begin
        case (addr)
          12'h000: m_latch = wr_data;
          12'h004: m_dir = wr_data;
          12'h008: m_en = wr_data;
          12'h00C: m_t0 = wr_data;
          12'h010: m_t1 = wr_data;
          12'h014: m_t2 = wr_data;
          12'h018: m_stat = m_stat & ~wr_data;
          default: ;
        endcase
      end
      seen.push_front(pin_in);
      void'(seen.pop_back());
    end
  end

  task automatic cmp(string req, string what, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      cmp(rst_n ? cur_req : "R1", "rd_data", rd_data, m_rd);
      cmp(rst_n ? "R10" : "R1", "irq", N'(irq), N'(|(m_stat & m_en)));
      cmp(rst_n ? "R2" : "R1", "pin_oe", pin_oe, m_dir);
      cmp("R2", "pin_out", pin_out, m_latch);
    end
  end

  task automatic wr(logic [11:0] a, logic [N-1:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic look(logic [11:0] a, int n);
    @(negedge clk);
    addr = a;
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    look(12'h018, 3);

    cur_req = "R2";
    wr(12'h004, 32'h0000_00FF);
    wr(12'h000, 32'hA5A5_5A5A);
    look(12'h004, 2);

    cur_req = "R3";
    pin_in = 32'h1234_0000;
    look(12'h000, 6);
    pin_in = 32'h8765_0000;
    look(12'h000, 1);
    look(12'h000, 4);

    cur_req = "R4";
    wr(12'h00C, 32'h0000_5600);
    wr(12'h010, 32'h0000_1800);
    wr(12'h014, 32'h0000_2400);
    pin_in = 32'h0000_0900;
    look(12'h00C, 2); look(12'h010, 2); look(12'h014, 2);
    wr(12'h008, 32'h0000_3F00);
    look(12'h008, 2);

    cur_req = "R5";
    look(12'h018, 4);
    pin_in = 32'h0000_0200;
    look(12'h018, 6);

    cur_req = "R8";
    wr(12'h018, 32'h0000_0000);
    look(12'h018, 2);
    wr(12'h018, 32'h0000_0003 << 8);
    look(12'h018, 3);

    cur_req = "R6";
    pin_in = 32'h0000_2600;
    look(12'h018, 5);
    wr(12'h018, 32'h0000_2400);
    pin_in = 32'h0000_0200;
    look(12'h018, 5);

    cur_req = "R7";
    wr(12'h018, 32'h0000_1800);
    look(12'h018, 3);
    pin_in = 32'h0000_1A00;
    look(12'h018, 4);
    wr(12'h018, 32'h0000_1000);
    look(12'h018, 3);

    cur_req = "R8";
    wr(12'h018, 32'hFFFF_FFFF);
    look(12'h018, 2);
    pin_in = 32'h0000_1800;
    @(negedge clk); @(negedge clk);
    addr = 12'h018; wr_data = 32'h0000_0200; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
    look(12'h018, 3);

    cur_req = "R9";
    pin_in = 32'h0000_5800;
    look(12'h018, 5);
    wr(12'h008, 32'h0000_0000);
    look(12'h018, 3);
    wr(12'h008, 32'h0000_3F00);
    look(12'h018, 3);

    cur_req = "R10";
    wr(12'h018, 32'hFFFF_FFFF);
    wr(12'h008, 32'h0000_0000);
    look(12'h018, 4);

    cur_req = "R11";
    wr(12'h01C, 32'hFFFF_FFFF);
    wr(12'h002, 32'hFFFF_FFFF);
    wr(12'h100, 32'hFFFF_FFFF);
    look(12'h01C, 2); look(12'h100, 2); look(12'h002, 2);
    look(12'h004, 2); look(12'h008, 2); look(12'h000, 2);

    cur_req = "R1";
    rst_n = 0;
    look(12'h004, 3);
    rst_n = 1;
    look(12'h018, 3);
    finish_run();
  end
endmodule